// File: doc/BRIEF.md
# Dual-Path Self-Synchronizing Byte Whitener

This block whitens two independent byte streams, a low-latency path and an interleaved path, after framing and checksum insertion and before block error-correction coding. Each path has its own 23-stage self-synchronizing scrambler, so the output bits of each stream become practically uncorrelated. The feedback polynomial is 1 + x^-18 + x^-23. A byte is processed in one clock cycle: eight serial bit steps are unrolled in combinational logic, starting with the least significant bit.

Each path has a byte-wide input and a byte-wide output. Both use valid/ready handshakes and carry a frame-start flag with the byte. Each path has its own enable and its own seed-clear control. A matching descrambler sits behind each scrambler output. It watches the bytes that leave the block and recovers the original stream on a loopback port, which lets the surrounding logic check the round trip.

Top module: `dp_whitener`

## Requirements
- R1: After reset, `*_out_valid` and `*_lb_valid` are low, `*_in_ready` is high, and both scrambler states and both descrambler states are all zero. As a result, a 0x00 byte sent after reset with the enable high comes out as 0x00.
- R2: With the path enable high, the path scrambles each accepted byte bit by bit, starting at bit 0. Each output bit is the input bit XOR the output bits produced 18 and 23 bit steps earlier. Each output bit is then shifted into that path's 23-bit history.
- R3: The two paths have separate state. Traffic, enable or seed-clear on one path never changes the bytes produced on the other path.
- R4: A byte accepted while the path enable is low leaves the block unchanged, and that path's scrambler history does not advance.
- R5: A seed-clear pulse sets that path's scrambler history to zero. A byte accepted in the same cycle is still scrambled with the history held before the clear.
- R6: A byte accepted at a clock edge appears on the output after that same edge. While the output is ready, the path accepts one byte every cycle.
- R7: While `*_out_valid` is high and `*_out_ready` is low, the output byte and frame-start flag hold steady. The input side accepts nothing in that state.
- R8: The frame-start flag of each byte reaches the output and the loopback port together with that byte.
- R9: The loopback descrambler shifts the received scrambled bits (not its own outputs) into its history. Each loopback bit is the received bit XOR the received bits 18 and 23 steps earlier. The loopback byte appears one cycle after the output handshake and equals the original input once 24 or more scrambled bits have passed since the last seed-clear.
- R10: A byte that was passed through with the enable low also passes through the loopback descrambler unchanged and does not advance its history. Seed-clear does not touch the descrambler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_en | input | 1 | Scramble enable, low-latency path |
| fast_clr | input | 1 | Seed-clear pulse, low-latency path |
| fast_in_data | input | 8 | Input byte, low-latency path |
| fast_in_valid | input | 1 | Input byte valid |
| fast_in_ready | output | 1 | Input byte can be accepted |
| fast_in_sof | input | 1 | Frame-start flag with input byte |
| fast_out_data | output | 8 | Whitened byte |
| fast_out_valid | output | 1 | Whitened byte valid |
| fast_out_ready | input | 1 | Downstream accepts whitened byte |
| fast_out_sof | output | 1 | Frame-start flag with whitened byte |
| fast_lb_data | output | 8 | Descrambled loopback byte |
| fast_lb_valid | output | 1 | Loopback byte valid (one-cycle pulse) |
| fast_lb_sof | output | 1 | Frame-start flag with loopback byte |
| ilv_en | input | 1 | Scramble enable, interleaved path |
| ilv_clr | input | 1 | Seed-clear pulse, interleaved path |
| ilv_in_data | input | 8 | Input byte, interleaved path |
| ilv_in_valid | input | 1 | Input byte valid |
| ilv_in_ready | output | 1 | Input byte can be accepted |
| ilv_in_sof | input | 1 | Frame-start flag with input byte |
| ilv_out_data | output | 8 | Whitened byte |
| ilv_out_valid | output | 1 | Whitened byte valid |
| ilv_out_ready | input | 1 | Downstream accepts whitened byte |
| ilv_out_sof | output | 1 | Frame-start flag with whitened byte |
| ilv_lb_data | output | 8 | Descrambled loopback byte |
| ilv_lb_valid | output | 1 | Loopback byte valid (one-cycle pulse) |
| ilv_lb_sof | output | 1 | Frame-start flag with loopback byte |

## Verification
The hardest case to reach from the ports is the moment after a seed-clear. The scrambler history restarts at zero, but the loopback descrambler still holds the bits it saw before the clear. Its loopback bytes therefore differ from the input for exactly three enabled bytes and then lock again. The stimulus creates this by clearing one path in the middle of a stream, once with a byte in the same cycle and once without. It mixes in enable-low bytes that must not count toward relock, and it keeps the other path running all the while. A reference model in the bench predicts each whitened and loopback byte, and marks the loopback bytes that must equal the original input. Random output stalls are also applied, so that bytes sit in the output register while clears and enable changes arrive.

// File: rtl/dpw_pkg.sv
package dpw_pkg;

   // Default geometry of the whitening sequence.
   localparam int unsigned DPW_BYTE_W  = 8;
   localparam int unsigned DPW_HIST_W  = 23;
   localparam int unsigned DPW_TAP_NEAR = 18;

   // Direction of the bit chain: scrambler shifts its output bits into the
   // history, descrambler shifts its received bits.
   typedef enum logic {
      DPW_WHITEN   = 1'b0,
      DPW_UNWHITEN = 1'b1
   } dpw_dir_e;

endpackage

// File: rtl/dpw_bit_chain.sv
// Combinational unrolled bit-serial whitening step for one word.
// Bit 0 is processed first; each step produces one output bit and one
// new history word.
module dpw_bit_chain
   import dpw_pkg::*;
#(
   parameter int unsigned W    = DPW_BYTE_W,
   parameter int unsigned LEN  = DPW_HIST_W,
   parameter int unsigned TAP  = DPW_TAP_NEAR,
   parameter dpw_dir_e    DIR  = DPW_WHITEN
) (
   input  logic [W-1:0]   din,
   input  logic [LEN-1:0] hist,
   output logic [W-1:0]   dout,
   output logic [LEN-1:0] hist_nxt
);

   localparam int unsigned NEAR_IDX = TAP - 1;
   localparam int unsigned FAR_IDX  = LEN - 1;

   logic [LEN-1:0] stage [W+1];

   assign stage[0] = hist;

   for (genvar i = 0; i < W; i++) begin : g_step
      assign dout[i] = din[i] ^ stage[i][NEAR_IDX] ^ stage[i][FAR_IDX];
      if (DIR == DPW_WHITEN) begin : g_fb_out
         assign stage[i+1] = {stage[i][LEN-2:0], dout[i]};
      end else begin : g_fb_in
         assign stage[i+1] = {stage[i][LEN-2:0], din[i]};
      end
   end

   assign hist_nxt = stage[W];

endmodule

// File: rtl/dpw_hist_reg.sv
// History register with synchronous clear (priority) and advance.
module dpw_hist_reg #(
   parameter int unsigned LEN = 23
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           adv,
   input  logic [LEN-1:0] nxt,
   output logic [LEN-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (clr) begin
         q <= '0;
      end else if (adv) begin
         q <= nxt;
      end
   end

endmodule

// File: rtl/dpw_path.sv
// One whitening path: scrambler + output register + loopback descrambler.
module dpw_path
   import dpw_pkg::*;
#(
   parameter int unsigned W   = DPW_BYTE_W,
   parameter int unsigned LEN = DPW_HIST_W,
   parameter int unsigned TAP = DPW_TAP_NEAR
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         clr,
   input  logic [W-1:0] in_data,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic         in_sof,
   output logic [W-1:0] out_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic         out_sof,
   output logic [W-1:0] lb_data,
   output logic         lb_valid,
   output logic         lb_sof
);

   logic           take;
   logic           give;
   logic [LEN-1:0] sc_hist;
   logic [LEN-1:0] sc_hist_nxt;
   logic [W-1:0]   sc_word;
   logic [LEN-1:0] ds_hist;
   logic [LEN-1:0] ds_hist_nxt;
   logic [W-1:0]   ds_word;
   logic           out_en;

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;
   assign give     = out_valid && out_ready;

   // ---------------- scrambler side ----------------
   dpw_bit_chain #(
      .W   (W),
      .LEN (LEN),
      .TAP (TAP),
      .DIR (DPW_WHITEN)
   ) u_sc_chain (
      .din      (in_data),
      .hist     (sc_hist),
      .dout     (sc_word),
      .hist_nxt (sc_hist_nxt)
   );

   dpw_hist_reg #(
      .LEN (LEN)
   ) u_sc_hist (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .adv   (take && en),
      .nxt   (sc_hist_nxt),
      .q     (sc_hist)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_sof   <= 1'b0;
         out_en    <= 1'b0;
      end else begin
         if (take) begin
            out_valid <= 1'b1;
            out_data  <= en ? sc_word : in_data;
            out_sof   <= in_sof;
            out_en    <= en;
         end else if (give) begin
            out_valid <= 1'b0;
         end
      end
   end

   // ---------------- loopback descrambler ----------------
   dpw_bit_chain #(
      .W   (W),
      .LEN (LEN),
      .TAP (TAP),
      .DIR (DPW_UNWHITEN)
   ) u_ds_chain (
      .din      (out_data),
      .hist     (ds_hist),
      .dout     (ds_word),
      .hist_nxt (ds_hist_nxt)
   );

   dpw_hist_reg #(
      .LEN (LEN)
   ) u_ds_hist (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (1'b0),
      .adv   (give && out_en),
      .nxt   (ds_hist_nxt),
      .q     (ds_hist)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lb_valid <= 1'b0;
         lb_data  <= '0;
         lb_sof   <= 1'b0;
      end else begin
         lb_valid <= give;
         if (give) begin
            lb_data <= out_en ? ds_word : out_data;
            lb_sof  <= out_sof;
         end
      end
   end

endmodule

// File: rtl/dp_whitener.sv
// Two independent whitening paths (low-latency and interleaved).
module dp_whitener
   import dpw_pkg::*;
#(
   parameter int unsigned W   = DPW_BYTE_W,
   parameter int unsigned LEN = DPW_HIST_W,
   parameter int unsigned TAP = DPW_TAP_NEAR
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fast_en,
   input  logic         fast_clr,
   input  logic [W-1:0] fast_in_data,
   input  logic         fast_in_valid,
   output logic         fast_in_ready,
   input  logic         fast_in_sof,
   output logic [W-1:0] fast_out_data,
   output logic         fast_out_valid,
   input  logic         fast_out_ready,
   output logic         fast_out_sof,
   output logic [W-1:0] fast_lb_data,
   output logic         fast_lb_valid,
   output logic         fast_lb_sof,
   input  logic         ilv_en,
   input  logic         ilv_clr,
   input  logic [W-1:0] ilv_in_data,
   input  logic         ilv_in_valid,
   output logic         ilv_in_ready,
   input  logic         ilv_in_sof,
   output logic [W-1:0] ilv_out_data,
   output logic         ilv_out_valid,
   input  logic         ilv_out_ready,
   output logic         ilv_out_sof,
   output logic [W-1:0] ilv_lb_data,
   output logic         ilv_lb_valid,
   output logic         ilv_lb_sof
);

   localparam int unsigned NPATH = 2;

   // Elaboration-time parameter checks.
   if (W < 1) begin : g_bad_w
      $error("dp_whitener: W must be at least 1");
   end
   if (LEN < 2) begin : g_bad_len
      $error("dp_whitener: LEN must be at least 2");
   end
   if (TAP < 1 || TAP >= LEN) begin : g_bad_tap
      $error("dp_whitener: TAP must lie in 1..LEN-1");
   end

   logic [NPATH-1:0] p_en, p_clr, p_in_valid, p_in_ready, p_in_sof;
   logic [NPATH-1:0] p_out_valid, p_out_ready, p_out_sof, p_lb_valid, p_lb_sof;
   logic [W-1:0]     p_in_data  [NPATH];
   logic [W-1:0]     p_out_data [NPATH];
   logic [W-1:0]     p_lb_data  [NPATH];

   assign p_en        = {ilv_en, fast_en};
   assign p_clr       = {ilv_clr, fast_clr};
   assign p_in_valid  = {ilv_in_valid, fast_in_valid};
   assign p_in_sof    = {ilv_in_sof, fast_in_sof};
   assign p_out_ready = {ilv_out_ready, fast_out_ready};
   assign p_in_data[0] = fast_in_data;
   assign p_in_data[1] = ilv_in_data;

   for (genvar p = 0; p < NPATH; p++) begin : g_path
      dpw_path #(
         .W   (W),
         .LEN (LEN),
         .TAP (TAP)
      ) u_path (
         .clk       (clk),
         .rst_n     (rst_n),
         .en        (p_en[p]),
         .clr       (p_clr[p]),
         .in_data   (p_in_data[p]),
         .in_valid  (p_in_valid[p]),
         .in_ready  (p_in_ready[p]),
         .in_sof    (p_in_sof[p]),
         .out_data  (p_out_data[p]),
         .out_valid (p_out_valid[p]),
         .out_ready (p_out_ready[p]),
         .out_sof   (p_out_sof[p]),
         .lb_data   (p_lb_data[p]),
         .lb_valid  (p_lb_valid[p]),
         .lb_sof    (p_lb_sof[p])
      );
   end

   assign fast_in_ready  = p_in_ready[0];
   assign fast_out_data  = p_out_data[0];
   assign fast_out_valid = p_out_valid[0];
   assign fast_out_sof   = p_out_sof[0];
   assign fast_lb_data   = p_lb_data[0];
   assign fast_lb_valid  = p_lb_valid[0];
   assign fast_lb_sof    = p_lb_sof[0];

   assign ilv_in_ready   = p_in_ready[1];
   assign ilv_out_data   = p_out_data[1];
   assign ilv_out_valid  = p_out_valid[1];
   assign ilv_out_sof    = p_out_sof[1];
   assign ilv_lb_data    = p_lb_data[1];
   assign ilv_lb_valid   = p_lb_valid[1];
   assign ilv_lb_sof     = p_lb_sof[1];

endmodule

// File: rtl/dpw_chk.sv
// Port-level protocol checker for one path, bound twice into dp_whitener.
module dpw_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         en,
   input logic [W-1:0] in_data,
   input logic         in_valid,
   input logic         in_ready,
   input logic         in_sof,
   input logic [W-1:0] out_data,
   input logic         out_valid,
   input logic         out_ready,
   input logic         out_sof,
   input logic         lb_valid
);

   // R6: accepted byte shows up after the same edge
   a_r6_accept_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   // R7: stalled output holds
   a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof)));

   // R4: disabled byte leaves unchanged
   a_r4_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !en) |=> (out_data == $past(in_data)));

   // R8: frame-start flag travels with the byte
   a_r8_sof_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_sof == $past(in_sof)));

   // R9: loopback byte one cycle after output handshake, never otherwise
   a_r9_lb_after_give: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=> lb_valid);
   a_r9_lb_only_after_give: assert property (@(posedge clk) disable iff (!rst_n)
      lb_valid |-> $past(out_valid && out_ready));

   // R1: output valid never appears without an accepted byte
   a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready));

endmodule

bind dp_whitener dpw_chk #(.W(W)) u_chk_fast (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (fast_en),
   .in_data   (fast_in_data),
   .in_valid  (fast_in_valid),
   .in_ready  (fast_in_ready),
   .in_sof    (fast_in_sof),
   .out_data  (fast_out_data),
   .out_valid (fast_out_valid),
   .out_ready (fast_out_ready),
   .out_sof   (fast_out_sof),
   .lb_valid  (fast_lb_valid)
);

bind dp_whitener dpw_chk #(.W(W)) u_chk_ilv (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (ilv_en),
   .in_data   (ilv_in_data),
   .in_valid  (ilv_in_valid),
   .in_ready  (ilv_in_ready),
   .in_sof    (ilv_in_sof),
   .out_data  (ilv_out_data),
   .out_valid (ilv_out_valid),
   .out_ready (ilv_out_ready),
   .out_sof   (ilv_out_sof),
   .lb_valid  (ilv_lb_valid)
);

// File: tb/sim_dp_whitener.sv
module sim_dp_whitener;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic       en [2], clr [2], in_valid [2], in_sof [2], out_ready [2];
   logic [7:0] in_data [2];
   logic       in_ready [2], out_valid [2], out_sof [2], lb_valid [2], lb_sof [2];
   logic [7:0] out_data [2], lb_data [2];

   dp_whitener u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .fast_en        (en[0]),
      .fast_clr       (clr[0]),
      .fast_in_data   (in_data[0]),
      .fast_in_valid  (in_valid[0]),
      .fast_in_ready  (in_ready[0]),
      .fast_in_sof    (in_sof[0]),
      .fast_out_data  (out_data[0]),
      .fast_out_valid (out_valid[0]),
      .fast_out_ready (out_ready[0]),
      .fast_out_sof   (out_sof[0]),
      .fast_lb_data   (lb_data[0]),
      .fast_lb_valid  (lb_valid[0]),
      .fast_lb_sof    (lb_sof[0]),
      .ilv_en         (en[1]),
      .ilv_clr        (clr[1]),
      .ilv_in_data    (in_data[1]),
      .ilv_in_valid   (in_valid[1]),
      .ilv_in_ready   (in_ready[1]),
      .ilv_in_sof     (in_sof[1]),
      .ilv_out_data   (out_data[1]),
      .ilv_out_valid  (out_valid[1]),
      .ilv_out_ready  (out_ready[1]),
      .ilv_out_sof    (out_sof[1]),
      .ilv_lb_data    (lb_data[1]),
      .ilv_lb_valid   (lb_valid[1]),
      .ilv_lb_sof     (lb_sof[1])
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;
   int cyc   = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // ---------------- reference model ----------------
   logic [22:0] m_sc [2];
   logic [22:0] m_ds [2];
   int          m_sync [2];

   function automatic logic [7:0] m_whiten(int p, logic [7:0] d);
      logic [7:0] o;
      for (int i = 0; i < 8; i++) begin
         o[i] = d[i] ^ m_sc[p][17] ^ m_sc[p][22];
         m_sc[p] = {m_sc[p][21:0], o[i]};
      end
      return o;
   endfunction

   function automatic logic [7:0] m_unwhiten(int p, logic [7:0] d);
      logic [7:0] o;
      for (int i = 0; i < 8; i++) begin
         o[i] = d[i] ^ m_ds[p][17] ^ m_ds[p][22];
         m_ds[p] = {m_ds[p][21:0], d[i]};
      end
      return o;
   endfunction

   // scoreboard queues: out {sof,data}; lb {synced,orig,sof,data}
   logic [8:0]  q_out0 [$], q_out1 [$];
   logic [17:0] q_lb0  [$], q_lb1  [$];

   task automatic push_exp(int p, logic [8:0] o, logic [17:0] l);
      if (p == 0) begin q_out0.push_back(o); q_lb0.push_back(l); end
      else        begin q_out1.push_back(o); q_lb1.push_back(l); end
   endtask

   // Driver: caller sits at posedge+1.
   task automatic send(int p, logic [7:0] d, logic s, logic e, logic c);
      logic [7:0] w, l;
      bit         syn;
      in_data[p]  = d;
      in_sof[p]   = s;
      en[p]       = e;
      clr[p]      = c;
      in_valid[p] = 1'b1;
      do @(negedge clk); while (!in_ready[p]);
      if (e) begin
         w = m_whiten(p, d);
         l = m_unwhiten(p, w);
         syn = (m_sync[p] >= 3);
         m_sync[p]++;
      end else begin
         w = d;
         l = d;
         syn = 1'b1;
      end
      push_exp(p, {s, w}, {syn, d, s, l});
      if (c) begin
         m_sc[p] = '0;
         m_sync[p] = 0;
      end
      @(posedge clk); #1;
      in_valid[p] = 1'b0;
      clr[p]      = 1'b0;
   endtask

   task automatic clear_only(int p);
      clr[p] = 1'b1;
      @(posedge clk); #1;
      clr[p] = 1'b0;
      m_sc[p] = '0;
      m_sync[p] = 0;
   endtask

   task automatic burst(int p, int n, logic [7:0] seed, logic e);
      logic [7:0] v = seed;
      for (int i = 0; i < n; i++) begin
         send(p, v, (i % 16) == 0, e, 1'b0);
         v = {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]} + 8'(i);
      end
   endtask

   // ---------------- output ready driver ----------------
   bit        bp_on [2];
   logic [15:0] bp_lfsr [2];

   always @(posedge clk) begin
      #1;
      for (int p = 0; p < 2; p++) begin
         bp_lfsr[p] = {bp_lfsr[p][14:0], bp_lfsr[p][15] ^ bp_lfsr[p][13] ^ bp_lfsr[p][12] ^ bp_lfsr[p][10]};
         out_ready[p] = bp_on[p] ? bp_lfsr[p][0] | bp_lfsr[p][3] : 1'b1;
      end
   end

   // ---------------- monitors ----------------
   bit         stall_prev [2];
   logic [8:0] stall_val  [2];

   task automatic monitor(int p);
      logic [8:0]  e;
      logic [17:0] l;
      if (stall_prev[p]) begin
         check(out_valid[p] && ({out_sof[p], out_data[p]} == stall_val[p]),
               "R7 stalled output held", {out_valid[p], out_sof[p], out_data[p]}, {1'b1, stall_val[p]});
      end
      stall_prev[p] = out_valid[p] && !out_ready[p];
      stall_val[p]  = {out_sof[p], out_data[p]};
      if (out_valid[p] && out_ready[p]) begin
         if ((p == 0 ? q_out0.size() : q_out1.size()) == 0) begin
            check(0, "R6 unexpected output byte", {out_sof[p], out_data[p]}, 0);
         end else begin
            e = (p == 0) ? q_out0.pop_front() : q_out1.pop_front();
            check(out_data[p] == e[7:0], p == 0 ? "R2 fast whitened byte" : "R3 ilv whitened byte",
                  out_data[p], e[7:0]);
            check(out_sof[p] == e[8], "R8 out frame-start", out_sof[p], e[8]);
         end
      end
      if (lb_valid[p]) begin
         if ((p == 0 ? q_lb0.size() : q_lb1.size()) == 0) begin
            check(0, "R9 unexpected loopback byte", lb_data[p], 0);
         end else begin
            l = (p == 0) ? q_lb0.pop_front() : q_lb1.pop_front();
            check(lb_data[p] == l[7:0], "R10 loopback byte vs model", lb_data[p], l[7:0]);
            check(lb_sof[p] == l[8], "R8 loopback frame-start", lb_sof[p], l[8]);
            if (l[17]) check(lb_data[p] == l[16:9], "R9 loopback recovers input", lb_data[p], l[16:9]);
         end
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         monitor(0);
         monitor(1);
      end
   end

   task automatic drain();
      repeat (40) @(posedge clk);
      #1;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (WATCHDOG) @(posedge clk);
      check(0, "watchdog expired", 0, 1);
      finish_run();
   end

   // ---------------- stimulus ----------------
   initial begin
      int t0;
      for (int p = 0; p < 2; p++) begin
         en[p] = 1'b0; clr[p] = 1'b0; in_valid[p] = 1'b0; in_sof[p] = 1'b0;
         in_data[p] = '0; out_ready[p] = 1'b1; bp_on[p] = 0;
         bp_lfsr[p] = (p == 0) ? 16'hACE1 : 16'h1D2B;
         m_sc[p] = '0; m_ds[p] = '0; m_sync[p] = 3; stall_prev[p] = 0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      for (int p = 0; p < 2; p++) begin
         check(!out_valid[p], "R1 out_valid low after reset", out_valid[p], 0);
         check(!lb_valid[p], "R1 lb_valid low after reset", lb_valid[p], 0);
         check(in_ready[p], "R1 in_ready high after reset", in_ready[p], 1);
      end
      @(posedge clk); #1;

      // R1: zero history, zero byte stays zero
      send(0, 8'h00, 1'b1, 1'b1, 1'b0);
      // R2: several patterns on the fast path
      send(0, 8'hFF, 1'b0, 1'b1, 1'b0);
      send(0, 8'h01, 1'b0, 1'b1, 1'b0);
      send(0, 8'h80, 1'b0, 1'b1, 1'b0);
      send(0, 8'hA5, 1'b0, 1'b1, 1'b0);
      burst(0, 20, 8'h3C, 1'b1);

      // R6: throughput one byte per cycle with ready held high
      t0 = cyc;
      burst(0, 16, 8'h11, 1'b1);
      check((cyc - t0) == 16, "R6 one byte per cycle", cyc - t0, 16);

      // R3: both paths together
      fork
         burst(0, 30, 8'h5A, 1'b1);
         burst(1, 30, 8'hC3, 1'b1);
      join

      // R4 / R10: disabled bytes pass through, history holds
      burst(1, 6, 8'h77, 1'b0);
      burst(1, 10, 8'h19, 1'b1);
      send(0, 8'hE7, 1'b0, 1'b0, 1'b0);
      send(0, 8'h00, 1'b0, 1'b1, 1'b0);

      // R5: clear without byte, then descrambler relock (R9)
      clear_only(0);
      burst(0, 8, 8'h42, 1'b1);
      // R5: clear coinciding with a byte, other path busy (R3)
      fork
         begin
            send(0, 8'h96, 1'b1, 1'b1, 1'b1);
            send(0, 8'h00, 1'b0, 1'b1, 1'b0);
            send(0, 8'h13, 1'b0, 1'b0, 1'b0);
            burst(0, 6, 8'h29, 1'b1);
         end
         burst(1, 12, 8'h6E, 1'b1);
      join
      drain();

      // R7: random stalls, clears and enable changes under backpressure
      bp_on[0] = 1; bp_on[1] = 1;
      fork
         begin
            burst(0, 40, 8'hD1, 1'b1);
            send(0, 8'h44, 1'b1, 1'b1, 1'b1);
            burst(0, 10, 8'h08, 1'b0);
            burst(0, 30, 8'hB2, 1'b1);
         end
         begin
            burst(1, 50, 8'h2F, 1'b1);
            clear_only(1);
            burst(1, 30, 8'h90, 1'b1);
         end
      join
      drain();
      bp_on[0] = 0; bp_on[1] = 0;
      drain();

      // all expected items consumed
      check(q_out0.size() == 0 && q_out1.size() == 0, "R6 all output bytes seen",
            q_out0.size() + q_out1.size(), 0);
      check(q_lb0.size() == 0 && q_lb1.size() == 0, "R9 all loopback bytes seen",
            q_lb0.size() + q_lb1.size(), 0);
      finish_run();
   end

endmodule